// File: doc/BRIEF.md
# Barrier Completion Sequencer

This block decides when a synchronizing instruction may leave the completion stage. The completion logic raises a one-cycle start strobe and an operation code. The sequencer then holds the instruction until that operation's exit condition is met, and signals the end with a single-cycle done pulse. Three classes of operation are handled:

- Fixed-latency operations retire after a set number of cycles. The instruction-synchronize operation is one of these, and it also raises a refetch request at retirement.
- The store barrier waits a minimum time. It also waits for the store queue to report empty. When broadcast was enabled at start, it then issues a bus broadcast request and waits for an acknowledge. A retry response sends a new request.
- The translation-sync operation was already marked finished at dispatch. It now waits for an external synchronization input. With that input tied high, it retires as soon as possible.

The block handles one operation at a time and shows that through a busy output.

The machine has seven states:

| State | Purpose |
|---|---|
| IDLE | Waiting for a start strobe. |
| FIXED | Counts down a fixed latency. |
| DRAIN | Enforces the store barrier's minimum time and waits for an empty store queue. |
| BC_REQ | Drives the broadcast request for one cycle. |
| BC_WAIT | Samples acknowledge and retry. |
| XLATE_WAIT | Waits for the external synchronization input. |
| DONE | Drives the done pulse. |

The transitions are:

- IDLE to DONE, FIXED, DRAIN or XLATE_WAIT, on an accepted start, chosen by operation class.
- FIXED to DONE, when the count reaches zero.
- DRAIN to BC_REQ or DONE, when the count is zero and the queue is empty. BC_REQ is taken if broadcast was enabled at start.
- BC_REQ to BC_WAIT, always.
- BC_WAIT to DONE on acknowledge, or to BC_REQ on retry.
- XLATE_WAIT to DONE, when the external input is high.
- DONE to IDLE, always.

Top module: `barrier_retire_seq`

## Requirements

Cycle 0 is the cycle in which start is high while the block is idle. Cycle n is n clock edges later. Operation codes are:

| Code | Operation |
|---|---|
| 0 | Store barrier |
| 1 | Translation sync |
| 2 | Instruction sync |
| 3 | I/O ordering barrier |
| 4 | Read of the machine-state register |
| 5 to 7 | Treated like codes 3 and 4 |

- R1: After reset, done, broadcast request, refetch request and busy are all low.
- R2: An accepted start makes busy high from cycle 1 through the cycle of the done pulse.
- R3: Codes 3, 4, 5, 6 and 7 give done in cycle 1.
- R4: Code 2 gives done in cycle 2, with the refetch request high in that same cycle. Refetch is never high for any other code.
- R5: Code 0 with broadcast disabled and the store queue empty gives done in cycle 3.
- R6: Code 0 with broadcast disabled gives done in cycle e+1. Here e is the first cycle, at or after cycle 2, in which the store-queue-empty input is high.
- R7: For code 0, the broadcast-enable input is sampled only in cycle 0. When it was high, the request is driven for one cycle in the cycle where done would otherwise have appeared.
  - Responses are sampled only in the cycles after a request.
  - A retry drives a new request in the next cycle.
  - An acknowledge gives done in the next cycle, and wins over a simultaneous retry.
  - An acknowledge in a request cycle is ignored.
- R8: Code 1 gives done in the cycle after the first cycle, at or after cycle 1, in which the external synchronization input is high. With that input always high, done comes in cycle 2.
- R9: Done is high for exactly one cycle. In the following cycle busy is low and a new start is accepted.
- R10: A start strobe while busy is ignored. It changes neither the done timing nor the refetch request of the operation in progress.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe from completion |
| op_i | input | 3 | Operation code, sampled with start |
| bcast_en_i | input | 1 | Broadcast enable, sampled with start |
| sq_empty_i | input | 1 | Store queue holds no pending stores |
| bcast_ack_i | input | 1 | Broadcast accepted by the bus |
| bcast_retry_i | input | 1 | Broadcast must be repeated |
| xsync_i | input | 1 | External translation synchronization input |
| done_o | output | 1 | One-cycle pulse: the instruction may retire |
| bcast_req_o | output | 1 | One-cycle broadcast request per attempt |
| refetch_o | output | 1 | Refetch request, high with done for code 2 |
| busy_o | output | 1 | An operation is in progress |

## Verification

The hardest situation to reach is a store barrier whose broadcast is retried several times. The bus response then arrives a variable number of cycles after each request, and a spurious acknowledge lands in a request cycle.

The bench computes every request cycle and every response cycle in advance, from the drain cycle, the retry count and the response delay. It drives the acknowledge and retry inputs at those cycles and compares the request output cycle by cycle.

Random transactions vary the drain point, the external synchronization delay, the broadcast enable and the retry count. The broadcast-enable input is deliberately inverted after cycle 0, so that a design which fails to latch it is exposed.

// File: rtl/barrier_seq_pkg.sv
package barrier_seq_pkg;

    // Operation codes presented with the start strobe.
    localparam logic [2:0] OPC_STORE_BAR  = 3'd0;
    localparam logic [2:0] OPC_XLATE_SYNC = 3'd1;
    localparam logic [2:0] OPC_INSN_SYNC  = 3'd2;
    localparam logic [2:0] OPC_IO_ORDER   = 3'd3;
    localparam logic [2:0] OPC_MSR_READ   = 3'd4;

    typedef enum logic [1:0] {
        CL_FIXED,
        CL_STORE,
        CL_XLATE
    } op_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIXED,
        ST_DRAIN,
        ST_BC_REQ,
        ST_BC_WAIT,
        ST_XLATE_WAIT,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/bseq_op_decode.sv
module bseq_op_decode
    import barrier_seq_pkg::*;
#(
    parameter int CW         = 3,
    parameter int SB_LAT     = 3,
    parameter int ISYNC_LAT  = 2,
    parameter int SIMPLE_LAT = 1
) (
    input  logic [2:0]    op,
    output op_class_e     cls,
    output logic          wants_refetch,
    output logic          direct_done,
    output logic [CW-1:0] load_val
);

    // Latencies are counted from the accept edge; the DONE state adds one
    // cycle, so the counter is preloaded with latency minus two.
    localparam int SB_LOAD    = (SB_LAT > 1) ? SB_LAT - 2 : 0;
    localparam int ISYNC_LOAD = (ISYNC_LAT > 1) ? ISYNC_LAT - 2 : 0;
    localparam int SIMP_LOAD  = (SIMPLE_LAT > 1) ? SIMPLE_LAT - 2 : 0;

    always_comb begin
        cls           = CL_FIXED;
        wants_refetch = 1'b0;
        direct_done   = 1'b0;
        load_val      = '0;
        unique case (op)
            OPC_STORE_BAR: begin
                cls      = CL_STORE;
                load_val = CW'(SB_LOAD);
            end
            OPC_XLATE_SYNC: begin
                cls = CL_XLATE;
            end
            OPC_INSN_SYNC: begin
                wants_refetch = 1'b1;
                direct_done   = (ISYNC_LAT <= 1);
                load_val      = CW'(ISYNC_LOAD);
            end
            default: begin
                direct_done = (SIMPLE_LAT <= 1);
                load_val    = CW'(SIMP_LOAD);
            end
        endcase
    end

endmodule

// File: rtl/bseq_down_cnt.sv
module bseq_down_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/barrier_retire_seq.sv
module barrier_retire_seq
    import barrier_seq_pkg::*;
#(
    parameter int SB_LAT     = 3,
    parameter int ISYNC_LAT  = 2,
    parameter int SIMPLE_LAT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] op_i,
    input  logic       bcast_en_i,
    input  logic       sq_empty_i,
    input  logic       bcast_ack_i,
    input  logic       bcast_retry_i,
    input  logic       xsync_i,
    output logic       done_o,
    output logic       bcast_req_o,
    output logic       refetch_o,
    output logic       busy_o
);

    localparam int MAX_LAT = (SB_LAT > ISYNC_LAT)
                           ? ((SB_LAT > SIMPLE_LAT) ? SB_LAT : SIMPLE_LAT)
                           : ((ISYNC_LAT > SIMPLE_LAT) ? ISYNC_LAT : SIMPLE_LAT);
    localparam int CW = $clog2(MAX_LAT + 1) + 1;

    seq_state_e    state_q, state_d;
    op_class_e     dec_cls;
    logic          dec_refetch;
    logic          dec_direct;
    logic [CW-1:0] dec_load;
    logic          accept;
    logic          cnt_zero;
    logic          cnt_dec;
    logic          bcast_en_q;
    logic          refetch_q;

    assign accept = start_i && (state_q == ST_IDLE);

    bseq_op_decode #(
        .CW         (CW),
        .SB_LAT     (SB_LAT),
        .ISYNC_LAT  (ISYNC_LAT),
        .SIMPLE_LAT (SIMPLE_LAT)
    ) u_decode (
        .op            (op_i),
        .cls           (dec_cls),
        .wants_refetch (dec_refetch),
        .direct_done   (dec_direct),
        .load_val      (dec_load)
    );

    assign cnt_dec = (state_q == ST_FIXED) || (state_q == ST_DRAIN);

    bseq_down_cnt #(
        .CW (CW)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (dec_load),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // Per-operation attributes captured at accept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcast_en_q <= 1'b0;
            refetch_q  <= 1'b0;
        end else if (accept) begin
            bcast_en_q <= bcast_en_i;
            refetch_q  <= dec_refetch;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (dec_cls)
                        CL_STORE: state_d = ST_DRAIN;
                        CL_XLATE: state_d = ST_XLATE_WAIT;
                        default:  state_d = dec_direct ? ST_DONE : ST_FIXED;
                    endcase
                end
            end
            ST_FIXED: begin
                if (cnt_zero) state_d = ST_DONE;
            end
            ST_DRAIN: begin
                if (cnt_zero && sq_empty_i) begin
                    state_d = bcast_en_q ? ST_BC_REQ : ST_DONE;
                end
            end
            ST_BC_REQ: begin
                state_d = ST_BC_WAIT;
            end
            ST_BC_WAIT: begin
                if (bcast_ack_i) begin
                    state_d = ST_DONE;
                end else if (bcast_retry_i) begin
                    state_d = ST_BC_REQ;
                end
            end
            ST_XLATE_WAIT: begin
                if (xsync_i) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output decode.
    always_comb begin
        done_o      = (state_q == ST_DONE);
        refetch_o   = (state_q == ST_DONE) && refetch_q;
        bcast_req_o = (state_q == ST_BC_REQ);
        busy_o      = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/barrier_retire_seq_chk.sv
module barrier_retire_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] op_i,
    input logic       bcast_en_i,
    input logic       sq_empty_i,
    input logic       bcast_ack_i,
    input logic       bcast_retry_i,
    input logic       xsync_i,
    input logic       done_o,
    input logic       bcast_req_o,
    input logic       refetch_o,
    input logic       busy_o
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R9

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_REFETCH_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        refetch_o |-> done_o); // R4

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_req_o |=> (!bcast_req_o && !done_o)); // R7

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_req_o |-> busy_o); // R7

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R10

    AST_SIMPLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i >= 3'd3)) |=> (done_o && !refetch_o)); // R3

    AST_XLATE_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i == 3'd1)) |=> !done_o); // R8

endmodule

bind barrier_retire_seq barrier_retire_seq_chk u_chk (.*);

// File: tb/barrier_retire_seq_tb.sv
`timescale 1ns/100ps
module barrier_retire_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic       bcast_en_i = 1'b0;
    logic       sq_empty_i = 1'b1;
    logic       bcast_ack_i = 1'b0;
    logic       bcast_retry_i = 1'b0;
    logic       xsync_i = 1'b0;
    logic       done_o, bcast_req_o, refetch_o, busy_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    barrier_retire_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .op_i          (op_i),
        .bcast_en_i    (bcast_en_i),
        .sq_empty_i    (sq_empty_i),
        .bcast_ack_i   (bcast_ack_i),
        .bcast_retry_i (bcast_retry_i),
        .xsync_i       (xsync_i),
        .done_o        (done_o),
        .bcast_req_o   (bcast_req_o),
        .refetch_o     (refetch_o),
        .busy_o        (busy_o)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Expected retirement cycle of a store barrier after draining.
    function automatic int drain_exit(int e);
        return imax(3, imax(e, 2) + 1);
    endfunction

    // Runs one operation starting in the current cycle (cycle 0).
    task automatic run_op(int op, bit ben, int e, int x, int nret, int dly,
                          bit stray_start, bit stray_ack, string tag);
        int rq[5];
        int rs[5];
        int d;
        int cur;
        bit use_bc;
        use_bc = (op == 0) && ben;
        d = 1;
        if (op == 0) begin
            cur = drain_exit(e);
            if (use_bc) begin
                for (int i = 0; i <= nret; i++) begin
                    rq[i] = cur;
                    rs[i] = cur + 1 + dly;
                    cur   = rs[i] + 1;
                end
            end
            d = cur;
        end else if (op == 1) begin
            d = imax(x, 1) + 1;
        end else if (op == 2) begin
            d = 2;
        end
        for (int k = 0; k <= d + 1; k++) begin
            bit exp_req;
            bit ack;
            bit rty;
            exp_req = 1'b0;
            ack = 1'b0;
            rty = 1'b0;
            if (use_bc) begin
                for (int i = 0; i <= nret; i++) begin
                    if (rq[i] == k) exp_req = 1'b1;
                    if (rs[i] == k) begin
                        if (i == nret) ack = 1'b1;
                        else           rty = 1'b1;
                    end
                end
                if (stray_ack && k == rq[0]) ack = 1'b1;
            end
            start_i       = (k == 0) || (stray_start && k == 1);
            op_i          = (k == 0) ? 3'(op) : 3'd2;
            bcast_en_i    = (k == 0) ? ben : ~ben;
            sq_empty_i    = (k >= e);
            xsync_i       = (k >= x);
            bcast_ack_i   = ack;
            bcast_retry_i = rty;
            if (k <= d) begin
                chk(tag, "done", done_o, (k == d));
                chk(tag, "refetch", refetch_o, (k == d) && (op == 2));
                chk(tag, "bcast_req", bcast_req_o, exp_req);
                chk("R2", "busy", busy_o, (k >= 1));
            end else begin
                chk("R9", "done after pulse", done_o, 1'b0);
                chk("R9", "busy after pulse", busy_o, 1'b0);
            end
            @(posedge clk);
            #1;
        end
        start_i       = 1'b0;
        bcast_ack_i   = 1'b0;
        bcast_retry_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "done in reset", done_o, 1'b0);
        chk("R1", "req in reset", bcast_req_o, 1'b0);
        chk("R1", "refetch in reset", refetch_o, 1'b0);
        chk("R1", "busy in reset", busy_o, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "busy after reset", busy_o, 1'b0);

        run_op(3, 0, 0, 0, 0, 0, 0, 0, "R3");
        run_op(4, 1, 0, 0, 0, 0, 0, 0, "R3");
        run_op(7, 0, 0, 0, 0, 0, 0, 0, "R3");
        run_op(2, 0, 0, 0, 0, 0, 0, 0, "R4");
        run_op(0, 0, 0, 0, 0, 0, 0, 0, "R5");
        run_op(0, 0, 6, 0, 0, 0, 0, 0, "R6");
        run_op(0, 0, 3, 0, 0, 0, 0, 0, "R6");
        run_op(0, 1, 0, 0, 0, 0, 0, 0, "R7");
        run_op(0, 1, 4, 0, 2, 1, 0, 1, "R7");
        run_op(0, 1, 0, 0, 3, 2, 0, 1, "R7");
        run_op(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        run_op(1, 0, 0, 5, 0, 0, 0, 0, "R8");
        run_op(0, 0, 0, 0, 0, 0, 1, 0, "R10");
        run_op(1, 0, 0, 3, 0, 0, 1, 0, "R10");
        run_op(3, 0, 0, 0, 0, 0, 1, 0, "R10");

        for (int t = 0; t < 60; t++) begin
            int    op;
            string tg;
            op = int'($urandom_range(0, 7));
            if (op == 0)      tg = "R7";
            else if (op == 1) tg = "R8";
            else if (op == 2) tg = "R4";
            else              tg = "R3";
            run_op(op, 1'($urandom_range(0, 1)), int'($urandom_range(0, 6)),
                   int'($urandom_range(0, 5)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), tg);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule